// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Converter Code Register Controller

This block sits behind a serial capture stage and receives one complete, already validated 16-bit command word at a time, marked by a single-cycle strobe. It decodes the word and keeps two banks of code registers for four converter channels. The staging bank holds codes written one channel at a time. The live bank holds the codes that drive the converters. A per-word flag chooses between two actions: only stage the new code, or stage it and then move every freshly staged code into the live bank in the same cycle.

Each channel tracks whether its staging register has been rewritten since its live register last took a value. A simultaneous load moves only those channels, so untouched channels see no update at all. The block also owns a global power-down state, which drives the per-channel output enables. When power-down is released, a settling counter drives a busy flag for a set number of clock cycles. A resolution parameter (8, 10 or 12) decides how many of the left-justified data bits are kept.

Top module: `qdac_reg_ctrl`

## Requirements
- R1: After reset every live code is zero, all four output enables are 1 (normal mode) and busy is 0.
- R2: Word bits 15:14 pick the channel that is written: 0 picks channel 0 (code_out[11:0]), 1 picks channel 1, 2 picks channel 2 and 3 picks channel 3 (code_out[47:36]).
- R3: Word bit 13 equal to 0 drives all four output enables to 0 from the cycle after the word. A word with bit 13 equal to 1 drives them to 1.
- R4: Data sits in word bits 11:0 and is left-justified. Each live code is 12 bits wide, and its lowest 12-RES bits are always 0 (RES=10 by default, so bits 1:0 are cleared).
- R5: A word with bit 12 equal to 1 writes only the addressed staging register. No live code changes.
- R6: A word with bit 12 equal to 0 first stages its own data. In the cycle after the word, every channel staged since its last load then takes its staged code at the same moment. Channels not staged since their last load keep their live code, and every pending mark is cleared.
- R7: Power-down leaves all registers intact. Words received during power-down still stage and load codes, and the live codes stay visible on code_out.
- R8: A word with bit 13 equal to 1, received while powered down, raises busy from the next cycle for exactly SETTLE_CYC cycles. The same word received in normal mode raises no busy.
- R9: A power-down word received while busy clears busy from the next cycle.
- R10: While cmd_valid is 0, cmd_word has no effect on codes, enables or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe marking a complete command word |
| cmd_word | input | 16 | Command word: channel, power, load mode, data |
| code_out | output | 48 | Four 12-bit live codes, channel 0 in the low bits |
| out_en | output | 4 | Per-channel output enable, 0 means high-impedance |
| busy | output | 1 | Power-up settling in progress |

## Verification
The case that needs the most care is a load-all word. In one clock it writes the addressed staging register and also moves every pending channel, including that same channel with its brand-new data, into the live bank. The bench stages three channels one by one, then sends a load-all word to the fourth, and checks that all four live codes change together on the first sample after that word and not before. A second load-all to a different channel then confirms that only the channels staged since the last load move.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int CODE_W = 12;
  localparam int NCH    = 4;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic [1:0]        chan;
    logic              pwr_on;
    logic              hold;
    logic [CODE_W-1:0] data;
  } cmd_t;

  // keep the top res bits of a left-justified code, clear the rest
  function automatic logic [CODE_W-1:0] trim_code(input logic [CODE_W-1:0] d, input int res);
    logic [CODE_W-1:0] keep;
    keep = '1;
    for (int b = 0; b < CODE_W; b++)
      if (b < CODE_W - res) keep[b] = 1'b0;
    return d & keep;
  endfunction
endpackage

// File: rtl/qdac_cmd_decode.sv
module qdac_cmd_decode
  import qdac_pkg::*;
#(
  parameter int RES = 10
) (
  input  logic                    cmd_valid,
  input  logic [WORD_W-1:0]       cmd_word,
  output logic [NCH-1:0]          wr_sel,
  output logic                    load_all,
  output logic                    pwr_word,
  output logic                    pwr_on,
  output logic [CODE_W-1:0]       code
);
  cmd_t cmd;
  assign cmd = cmd_t'(cmd_word);

  always_comb begin
    wr_sel = '0;
    if (cmd_valid) wr_sel[cmd.chan] = 1'b1;
  end

  assign load_all = cmd_valid & ~cmd.hold;
  assign pwr_word = cmd_valid;
  assign pwr_on   = cmd.pwr_on;
  assign code     = trim_code(cmd.data, RES);
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan
  import qdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              load_all,
  input  logic [CODE_W-1:0] wr_code,
  output logic [CODE_W-1:0] live_code,
  output logic              pend
);
  logic [CODE_W-1:0] stage_q;
  logic [CODE_W-1:0] live_q;
  logic              pend_q;
  logic              take;

  assign take = load_all & (pend_q | wr_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      live_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_en) stage_q <= wr_code;
      if (take)  live_q  <= wr_en ? wr_code : stage_q;
      if (load_all)   pend_q <= 1'b0;
      else if (wr_en) pend_q <= 1'b1;
    end
  end

  assign live_code = live_q;
  assign pend      = pend_q;
endmodule

// File: rtl/qdac_pwr_ctrl.sv
module qdac_pwr_ctrl #(
  parameter int SETTLE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_word,
  input  logic pwr_on,
  output logic pd,
  output logic busy
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 2);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC);

  logic             pd_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (pwr_word) pd_q <= ~pwr_on;
      if (pwr_word && !pwr_on)     cnt_q <= '0;
      else if (pwr_word && pd_q)   cnt_q <= SETTLE_LD;
      else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pd   = pd_q;
  assign busy = (cnt_q != '0);
endmodule

// File: rtl/qdac_reg_ctrl.sv
module qdac_reg_ctrl
  import qdac_pkg::*;
#(
  parameter int RES        = 10,
  parameter int SETTLE_CYC = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [15:0]            cmd_word,
  output logic [47:0]            code_out,
  output logic [3:0]             out_en,
  output logic                   busy
);
  logic [NCH-1:0]    wr_sel;
  logic              load_all;
  logic              pwr_word;
  logic              pwr_on;
  logic [CODE_W-1:0] new_code;
  logic [NCH-1:0]    pend;
  logic              pd;

  qdac_cmd_decode #(.RES(RES)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .wr_sel    (wr_sel),
    .load_all  (load_all),
    .pwr_word  (pwr_word),
    .pwr_on    (pwr_on),
    .code      (new_code)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    qdac_chan u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_sel[i]),
      .load_all  (load_all),
      .wr_code   (new_code),
      .live_code (code_out[i*CODE_W +: CODE_W]),
      .pend      (pend[i])
    );
  end

  qdac_pwr_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_word (pwr_word),
    .pwr_on   (pwr_on),
    .pd       (pd),
    .busy     (busy)
  );

  assign out_en = {NCH{~pd}};
endmodule

// File: rtl/qdac_reg_ctrl_chk.sv
module qdac_reg_ctrl_chk #(
  parameter int RES        = 10,
  parameter int SETTLE_CYC = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [15:0] cmd_word,
  input logic [47:0] code_out,
  input logic [3:0]  out_en,
  input logic        busy,
  input logic [3:0]  pend
);
  localparam logic [11:0] LOW_MASK = ~(12'hFFF << (12 - RES));

  a_r5_staged_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_word[12]) |=> $stable(code_out));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(code_out) && $stable(out_en)));

  a_r3_pd_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_word[13]) |=> (out_en == 4'h0));

  a_r3_on_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_word[13]) |=> (out_en == 4'hF));

  a_r6_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_word[12]) |=> (pend == 4'h0));

  a_r8_busy_normal: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (out_en == 4'hF));

  a_r9_busy_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_word[13]) |=> !busy);

  generate
    if (SETTLE_CYC > 0) begin : g_busy
      a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[13] && out_en == 4'h0) |=> busy);
    end
  endgenerate

  for (genvar i = 0; i < 4; i++) begin : g_ch
    a_r6_unpend_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_word[12] && !pend[i] && cmd_word[15:14] != 2'(i))
        |=> $stable(code_out[i*12 +: 12]));

    a_r4_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (code_out[i*12 +: 12] & LOW_MASK) == 12'h000);
  end
endmodule

bind qdac_reg_ctrl qdac_reg_ctrl_chk #(.RES(RES), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_word  (cmd_word),
  .code_out  (code_out),
  .out_en    (out_en),
  .busy      (busy),
  .pend      (pend)
);

// File: tb/tb_qdac_reg_ctrl.sv
module tb_qdac_reg_ctrl;
  localparam int RES    = 10;
  localparam int SETTLE = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [47:0] code_out;
  logic [3:0]  out_en;
  logic        busy;

  int n_chk = 0;
  int n_bad = 0;
  logic [11:0] exp_code [4];

  always #4 clk = ~clk;

  qdac_reg_ctrl #(.RES(RES), .SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .code_out(code_out), .out_en(out_en), .busy(busy)
  );

  function automatic logic [11:0] keep_bits(input logic [11:0] d);
    return (d >> (12 - RES)) << (12 - RES);
  endfunction

  function automatic logic [15:0] mk(input int ch, input bit on, input bit hold, input logic [11:0] d);
    return {ch[1:0], on, hold, d};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_codes(input string req);
    for (int i = 0; i < 4; i++)
      check(req, $sformatf("code ch%0d", i), 32'(code_out[i*12 +: 12]), 32'(exp_code[i]));
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = 16'hA5A5;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) exp_code[i] = '0;
    check_codes("R1");
    check("R1", "out_en", 32'(out_en), 32'hF);
    check("R1", "busy", 32'(busy), 32'h0);
  endtask

  task automatic t_staged;
    send(mk(0, 1, 1, 12'hABC));
    check_codes("R5");
    send(mk(1, 1, 1, 12'h123));
    send(mk(2, 1, 1, 12'h7FF));
    check_codes("R5");
  endtask

  task automatic t_load_all;
    send(mk(3, 1, 0, 12'hFFF));
    exp_code[0] = keep_bits(12'hABC);
    exp_code[1] = keep_bits(12'h123);
    exp_code[2] = keep_bits(12'h7FF);
    exp_code[3] = keep_bits(12'hFFF);
    check_codes("R6 R2 R4");
    check("R4", "ch1 low bits", 32'(code_out[13:12]), 32'h0);
  endtask

  task automatic t_partial;
    send(mk(1, 1, 1, 12'h456));
    check_codes("R5");
    send(mk(2, 1, 0, 12'h001));
    exp_code[1] = keep_bits(12'h456);
    exp_code[2] = keep_bits(12'h001);
    check_codes("R6 R2");
  endtask

  task automatic t_idle;
    @(negedge clk);
    cmd_word = mk(0, 0, 0, 12'h999);
    repeat (4) @(negedge clk);
    check_codes("R10");
    check("R10", "out_en", 32'(out_en), 32'hF);
    check("R10", "busy", 32'(busy), 32'h0);
  endtask

  task automatic t_power_down;
    send(mk(0, 0, 1, 12'h111));
    check("R3", "out_en pd", 32'(out_en), 32'h0);
    check_codes("R7");
    check("R3", "busy pd", 32'(busy), 32'h0);
    send(mk(0, 0, 0, 12'h222));
    exp_code[0] = keep_bits(12'h222);
    check_codes("R7");
    check("R7", "out_en still pd", 32'(out_en), 32'h0);
  endtask

  task automatic t_exit;
    int n;
    send(mk(1, 1, 1, 12'h333));
    check("R3", "out_en on", 32'(out_en), 32'hF);
    check("R8", "busy after exit", 32'(busy), 32'h1);
    check_codes("R7");
    count_busy(n);
    check("R8", "busy length", 32'(n), 32'(SETTLE));
    send(mk(2, 1, 1, 12'h000));
    check("R8", "no busy in normal", 32'(busy), 32'h0);
  endtask

  task automatic t_abort;
    int n;
    send(mk(3, 0, 1, 12'h000));
    send(mk(3, 1, 1, 12'h000));
    check("R8", "busy raised", 32'(busy), 32'h1);
    repeat (3) @(negedge clk);
    send(mk(3, 0, 1, 12'h000));
    check("R9", "busy cleared", 32'(busy), 32'h0);
    check("R9", "out_en pd", 32'(out_en), 32'h0);
    send(mk(3, 1, 1, 12'h000));
    count_busy(n);
    check("R8", "busy length again", 32'(n), 32'(SETTLE));
    check_codes("R7");
  endtask

  initial begin
    #200000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_staged;
    t_load_all;
    t_partial;
    t_idle;
    t_power_down;
    t_exit;
    t_abort;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule